// File: doc/BRIEF.md
# Restorable Second-Order Recursive Filter Section

This block is one second-order recursive filter section in direct form II. Each accepted input sample updates a single recursion value `w(n) = x(n) + a1*w(n-1) + a2*w(n-2)`. The block then forms the output `y(n) = b0*w(n) + b1*w(n-1) + b2*w(n-2)` and shifts `w(n)` into a two-deep delay line.

Samples are 16-bit two's complement. Coefficients are 16-bit signed values with 14 fraction bits, so they cover roughly -2.0 to +2.0. Sums are formed in a wide accumulator. Each sum is then rounded and clamped back to 16 bits.

The block is built for stop-and-resume debugging, with two hooks:
- Every output beat also carries the recursion value `w(n)` that the sample produced, so the block's whole state is always visible.
- A load flag, sampled with each input beat, replaces the computed `w(n)` with an externally supplied value.

To carry a run over to another copy of the block:
1. Record the last two `state_out` values.
2. Feed them back as two load beats: the older value first, then the newer one.
3. Continue with the original input.

The copy then produces exactly the same outputs as the original run.

Both data interfaces are valid/ready streams:
- An input beat is taken on a clock edge where `in_valid` and `in_ready` are both high.
- An output beat is handed over on an edge where `out_valid` and `out_ready` are both high.
- While an output beat is waiting, the block accepts nothing and holds the output fields steady.
- `in_ready` follows combinationally from the output side, so one beat per cycle flows when the consumer never stalls.

Coefficient inputs are plain levels. They are read whenever an input beat is taken.

Top module: `biquad_dbg_section`

## Requirements
- R1: A synchronous active-high `rst` clears both delay stages and the output register. After reset, `out_valid` is 0, `out_sample` is 0 and `state_out` is 0.
- R2: With `state_load` low, an accepted beat computes `w = clamp(floor((x*2^14 + a1*w1 + a2*w2 + 2^13) / 2^14))`. Here `w1` and `w2` are the two previous recursion values, and clamp limits the result to [-32768, 32767].
- R3: The output of a beat is `y = clamp(floor((b0*w + b1*w1 + b2*w2 + 2^13) / 2^14))`, using the same rounding and limits as R2.
- R4: Results that overflow saturate. A recursion value or output above 32767 becomes 32767, and one below -32768 becomes -32768.
- R5: The delay stages advance only on an accepted beat. Idle cycles and stalled cycles leave them unchanged, so the next result is the same as if there had been no gap.
- R6: `out_valid` is high in the cycle after an accepted beat. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_sample` and `state_out` do not change.
- R7: `in_ready` equals `!out_valid || out_ready`.
- R8: When `state_load` is high on an accepted beat, `w` takes the value of `state_in` instead of the R2 result. The output of that beat is formed from this loaded value, and `state_out` reports it.
- R9: Every output beat presents, on `state_out`, the recursion value `w` of the same beat.
- R10: Loading the last two reported `state_out` values, older first, into a freshly reset section makes it reproduce the original section's later output stream bit for bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Section can take an input beat |
| in_sample | input | 16 | Input sample, signed |
| state_load | input | 1 | Replace the recursion value of this beat |
| state_in | input | 16 | Recursion value used when `state_load` is high |
| coef_a1 | input | 16 | Feedback coefficient on `w(n-1)`, signed, 14 fraction bits |
| coef_a2 | input | 16 | Feedback coefficient on `w(n-2)`, signed, 14 fraction bits |
| coef_b0 | input | 16 | Feed-forward coefficient on `w(n)`, signed, 14 fraction bits |
| coef_b1 | input | 16 | Feed-forward coefficient on `w(n-1)`, signed, 14 fraction bits |
| coef_b2 | input | 16 | Feed-forward coefficient on `w(n-2)`, signed, 14 fraction bits |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_sample | output | 16 | Filtered sample, signed |
| state_out | output | 16 | Recursion value `w(n)` of this output beat |

## Verification
The hardest case to reach is resuming a run partway through while the consumer is stalling. A stall at the wrong moment could drop a state update or apply it twice, and the outputs that follow would drift apart.

The stimulus works as follows:
1. Run a stable filter with random gaps and random back-pressure.
2. Capture the last two reported state values.
3. Record the next stretch of outputs.
4. Reset the section and feed the two captured states back as load beats.
5. Replay the same input stretch and compare the new stream with the recorded one, word for word.

A separate high-gain phase drives both the recursion and the output into positive and negative saturation.

// File: rtl/biquad_pkg.sv
`timescale 1ns/1ps
package biquad_pkg;
  // Source of the recursion value for one accepted beat
  typedef enum logic {
    WSRC_RECUR = 1'b0,
    WSRC_LOAD  = 1'b1
  } wsrc_e;

  localparam int SAMPLE_W_DEF = 16;
  localparam int COEF_W_DEF   = 16;
  localparam int FRAC_DEF     = 14;
  localparam int GUARD_DEF    = 3;
endpackage

// File: rtl/biquad_dot.sv
`timescale 1ns/1ps
// Bias plus a sum of NT signed products in a wide accumulator
module biquad_dot #(
  parameter int NT = 3,
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int AW = 35
) (
  input  logic signed [AW-1:0] bias,
  input  logic signed [DW-1:0] tap  [NT],
  input  logic signed [CW-1:0] coef [NT],
  output logic signed [AW-1:0] sum
);
  localparam int PW = DW + CW;

  logic signed [PW-1:0] prod [NT];

  generate
    for (genvar i = 0; i < NT; i++) begin : g_term
      assign prod[i] = tap[i] * coef[i];
    end
  endgenerate

  always_comb begin
    sum = bias;
    for (int i = 0; i < NT; i++) begin
      sum = sum + AW'(prod[i]);
    end
  end
endmodule

// File: rtl/biquad_quant.sv
`timescale 1ns/1ps
// Round half up, drop FRAC bits, clamp to the DW-bit signed range
module biquad_quant #(
  parameter int AW   = 35,
  parameter int DW   = 16,
  parameter int FRAC = 14
) (
  input  logic signed [AW-1:0] acc,
  output logic signed [DW-1:0] q
);
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (FRAC - 1);
  localparam logic signed [AW-1:0] HI   = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW-1:0] LO   = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [AW-1:0] rounded;
  logic signed [AW-1:0] shifted;

  always_comb begin
    rounded = acc + HALF;
    shifted = rounded >>> FRAC;
    if (shifted > HI) begin
      q = HI[DW-1:0];
    end else if (shifted < LO) begin
      q = LO[DW-1:0];
    end else begin
      q = shifted[DW-1:0];
    end
  end
endmodule

// File: rtl/biquad_delay.sv
`timescale 1ns/1ps
// Two-deep recursion delay line, advancing on accepted beats only
module biquad_delay #(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic [DW-1:0]     w_new,
  output logic [DW-1:0]     w1,
  output logic [DW-1:0]     w2
);
  always_ff @(posedge clk) begin
    if (rst) begin
      w1 <= '0;
      w2 <= '0;
    end else if (adv) begin
      w1 <= w_new;
      w2 <= w1;
    end
  end

  // R5: no accepted beat, no movement of the delay line
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !adv |=> ($stable(w1) && $stable(w2)));

  // R5: on a beat the older stage takes the former newer stage
  p_shift_order_r5: assert property (@(posedge clk) disable iff (rst)
    adv |=> (w2 == $past(w1) && w1 == $past(w_new)));
endmodule

// File: rtl/biquad_dbg_section.sv
`timescale 1ns/1ps
module biquad_dbg_section
  import biquad_pkg::*;
#(
  parameter int SAMPLE_W = SAMPLE_W_DEF,
  parameter int COEF_W   = COEF_W_DEF,
  parameter int FRAC     = FRAC_DEF,
  parameter int GUARD    = GUARD_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic                state_load,
  input  logic [SAMPLE_W-1:0] state_in,
  input  logic [COEF_W-1:0]   coef_a1,
  input  logic [COEF_W-1:0]   coef_a2,
  input  logic [COEF_W-1:0]   coef_b0,
  input  logic [COEF_W-1:0]   coef_b1,
  input  logic [COEF_W-1:0]   coef_b2,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_sample,
  output logic [SAMPLE_W-1:0] state_out
);
  localparam int ACC_W = SAMPLE_W + COEF_W + GUARD;
  localparam int NFB   = 2;
  localparam int NFF   = 3;

  logic accept;
  wsrc_e wsrc;

  logic [SAMPLE_W-1:0] w1, w2;
  logic signed [SAMPLE_W-1:0] w_calc, w_now, y_now;
  logic signed [ACC_W-1:0] fb_bias, fb_sum, ff_sum;
  logic signed [ACC_W-1:0] ff_bias;

  logic signed [SAMPLE_W-1:0] fb_tap [NFB];
  logic signed [COEF_W-1:0]   fb_cf  [NFB];
  logic signed [SAMPLE_W-1:0] ff_tap [NFF];
  logic signed [COEF_W-1:0]   ff_cf  [NFF];

  // Stream handshake: a waiting output beat blocks the input side
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign wsrc     = state_load ? WSRC_LOAD : WSRC_RECUR;

  // Feedback half: x aligned to the coefficient fraction, plus a1*w1 + a2*w2
  assign fb_bias   = ACC_W'($signed(in_sample)) <<< FRAC;
  assign fb_tap[0] = $signed(w1);
  assign fb_tap[1] = $signed(w2);
  assign fb_cf[0]  = $signed(coef_a1);
  assign fb_cf[1]  = $signed(coef_a2);

  biquad_dot #(.NT(NFB), .DW(SAMPLE_W), .CW(COEF_W), .AW(ACC_W)) u_fb_dot (
    .bias (fb_bias),
    .tap  (fb_tap),
    .coef (fb_cf),
    .sum  (fb_sum)
  );

  biquad_quant #(.AW(ACC_W), .DW(SAMPLE_W), .FRAC(FRAC)) u_fb_quant (
    .acc (fb_sum),
    .q   (w_calc)
  );

  // State override: the debug value replaces the recursion result
  always_comb begin
    unique case (wsrc)
      WSRC_LOAD:  w_now = $signed(state_in);
      default:    w_now = w_calc;
    endcase
  end

  // Feed-forward half
  assign ff_bias   = '0;
  assign ff_tap[0] = w_now;
  assign ff_tap[1] = $signed(w1);
  assign ff_tap[2] = $signed(w2);
  assign ff_cf[0]  = $signed(coef_b0);
  assign ff_cf[1]  = $signed(coef_b1);
  assign ff_cf[2]  = $signed(coef_b2);

  biquad_dot #(.NT(NFF), .DW(SAMPLE_W), .CW(COEF_W), .AW(ACC_W)) u_ff_dot (
    .bias (ff_bias),
    .tap  (ff_tap),
    .coef (ff_cf),
    .sum  (ff_sum)
  );

  biquad_quant #(.AW(ACC_W), .DW(SAMPLE_W), .FRAC(FRAC)) u_ff_quant (
    .acc (ff_sum),
    .q   (y_now)
  );

  biquad_delay #(.DW(SAMPLE_W)) u_delay (
    .clk   (clk),
    .rst   (rst),
    .adv   (accept),
    .w_new (w_now),
    .w1    (w1),
    .w2    (w2)
  );

  // Output register of the stream
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
      state_out  <= '0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_sample <= y_now;
      state_out  <= w_now;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // R6: a beat taken now is offered next cycle
  p_valid_next_r6: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);

  // R6: a stalled output beat is held unchanged
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_sample) && $stable(state_out)));

  // R8: a load beat reports the supplied value as its state
  p_load_value_r8: assert property (@(posedge clk) disable iff (rst)
    (accept && state_load) |=> (state_out == $past(state_in)));

  // R9: the reported state is the newest delay stage
  p_state_matches_r9: assert property (@(posedge clk) disable iff (rst)
    accept |=> (state_out == w1));
endmodule

// File: tb/biquad_dbg_section_test.sv
`timescale 1ns/1ps
module biquad_dbg_section_test;
  localparam int HALF_NS = 4;
  localparam int WD_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_sample = '0;
  logic        state_load = 1'b0;
  logic [15:0] state_in = '0;
  logic [15:0] coef_a1 = '0, coef_a2 = '0, coef_b0 = '0, coef_b1 = '0, coef_b2 = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_sample;
  logic [15:0] state_out;

  int checks = 0;
  int errors = 0;
  bit bp_en = 1'b0;

  // model state and coefficients
  longint m_w1 = 0, m_w2 = 0;
  longint ca1 = 0, ca2 = 0, cb0 = 0, cb1 = 0, cb2 = 0;

  // scoreboard queues
  int    exp_y[$];
  int    exp_w[$];
  string exp_tag[$];
  int    obs_y[$];
  int    obs_w[$];

  always #(HALF_NS) clk = ~clk;

  biquad_dbg_section uut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_sample(in_sample),
    .state_load(state_load), .state_in(state_in),
    .coef_a1(coef_a1), .coef_a2(coef_a2), .coef_b0(coef_b0),
    .coef_b1(coef_b1), .coef_b2(coef_b2),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sample(out_sample), .state_out(state_out)
  );

  function automatic longint qz(longint acc);
    longint r;
    r = (acc + longint'(8192)) >>> 14;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic set_coefs(input int a1, input int a2, input int b0,
                           input int b1, input int b2);
    ca1 = a1; ca2 = a2; cb0 = b0; cb1 = b1; cb2 = b2;
    coef_a1 = 16'(a1); coef_a2 = 16'(a2);
    coef_b0 = 16'(b0); coef_b1 = 16'(b1); coef_b2 = 16'(b2);
  endtask

  // Driver: offers one beat, waits for acceptance, pushes the expected result
  task automatic send(input int x, input bit ld, input int ls, input string tag);
    longint wn, yn;
    @(negedge clk);
    in_valid = 1'b1; in_sample = 16'(x); state_load = ld; state_in = 16'(ls);
    #3;
    while (!in_ready) begin
      @(posedge clk);
      #7;
    end
    @(posedge clk);
    wn = ld ? longint'(ls) : qz((longint'(x) <<< 14) + ca1 * m_w1 + ca2 * m_w2);
    yn = qz(cb0 * wn + cb1 * m_w1 + cb2 * m_w2);
    m_w2 = m_w1;
    m_w1 = wn;
    exp_y.push_back(int'(yn));
    exp_w.push_back(int'(wn));
    exp_tag.push_back(tag);
    #1;
    in_valid = 1'b0;
    state_load = 1'b0;
  endtask

  task automatic drain();
    while (exp_y.size() != 0) @(posedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_w1 = 0;
    m_w2 = 0;
  endtask

  // Consumer back-pressure, changing just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      out_ready = bp_en ? (($urandom % 4) != 0) : 1'b1;
    end
  end

  // Monitor: compares outputs against the scoreboard at falling edges
  initial begin
    bit   hold_pend = 1'b0;
    logic [15:0] h_y, h_w;
    forever begin
      @(negedge clk);
      if (rst) begin
        hold_pend = 1'b0;
      end else begin
        if (out_valid) begin
          check(in_ready === (!out_valid || out_ready), "R7", "in_ready",
                int'(in_ready), int'(!out_valid || out_ready));
        end
        if (hold_pend) begin
          check(out_valid === 1'b1 && out_sample === h_y && state_out === h_w,
                "R6", "stalled beat held", int'($signed(out_sample)), int'($signed(h_y)));
          hold_pend = 1'b0;
        end
        if (out_valid && !out_ready) begin
          hold_pend = 1'b1;
          h_y = out_sample;
          h_w = state_out;
        end
        if (out_valid && out_ready) begin
          if (exp_y.size() == 0) begin
            check(1'b0, "R6", "unexpected output beat", int'($signed(out_sample)), 0);
          end else begin
            int ey, ew;
            string tg;
            ey = exp_y.pop_front();
            ew = exp_w.pop_front();
            tg = exp_tag.pop_front();
            check(int'($signed(out_sample)) == ey, tg, "out_sample (R3)",
                  int'($signed(out_sample)), ey);
            check(int'($signed(state_out)) == ew, tg, "state_out (R2/R9)",
                  int'($signed(state_out)), ew);
            obs_y.push_back(int'($signed(out_sample)));
            obs_w.push_back(int'($signed(state_out)));
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int stim[36];
  int rec_a[$];

  initial begin
    int sv_old, sv_new;
    // R1: reset state
    do_reset();
    @(negedge clk);
    check(out_valid === 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(state_out === 16'd0, "R1", "state_out after reset", int'(state_out), 0);
    check(out_sample === 16'd0, "R1", "out_sample after reset", int'(out_sample), 0);
    check(in_ready === 1'b1, "R7", "in_ready when empty", int'(in_ready), 1);

    // R1/R2: first beat from a cleared state
    set_coefs(13107, -6554, 4096, 8192, 4096);
    send(100, 1'b0, 0, "R1");
    send(-200, 1'b0, 0, "R2");
    drain();

    // Main run with gaps and back-pressure (R2, R3, R5, R6, R7)
    bp_en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      int gap;
      gap = int'($urandom % 3);
      repeat (gap) @(negedge clk);
      send(int'($urandom % 40000) - 20000, 1'b0, 0, (gap > 0) ? "R5" : "R3");
    end
    // R8: a mid-run override
    send(500, 1'b1, -12345, "R8");
    send(1000, 1'b0, 0, "R8");
    send(-1000, 1'b0, 0, "R8");
    drain();

    // R10: save, continue, reset, restore, replay
    do_reset();
    obs_y.delete();
    obs_w.delete();
    for (int i = 0; i < 36; i++) stim[i] = int'($urandom % 30000) - 15000;
    for (int i = 0; i < 20; i++) send(stim[i], 1'b0, 0, "R10");
    drain();
    sv_old = obs_w[18];
    sv_new = obs_w[19];
    for (int i = 20; i < 36; i++) send(stim[i], 1'b0, 0, "R10");
    drain();
    for (int i = 20; i < 36; i++) rec_a.push_back(obs_y[i]);
    do_reset();
    obs_y.delete();
    obs_w.delete();
    send(0, 1'b1, sv_old, "R8");
    send(0, 1'b1, sv_new, "R8");
    for (int i = 20; i < 36; i++) send(stim[i], 1'b0, 0, "R10");
    drain();
    check(obs_y.size() == 18, "R10", "replayed beat count", obs_y.size(), 18);
    for (int i = 0; i < 16; i++) begin
      if (i + 2 < obs_y.size())
        check(obs_y[i+2] == rec_a[i], "R10", "resumed output", obs_y[i+2], rec_a[i]);
    end

    // R4: saturation both ways
    bp_en = 1'b0;
    do_reset();
    set_coefs(32000, 0, 32767, 0, 0);
    for (int i = 0; i < 8; i++) send(20000, 1'b0, 0, "R4");
    drain();
    check(int'($signed(state_out)) == 32767, "R4", "positive clamp of state",
          int'($signed(state_out)), 32767);
    for (int i = 0; i < 10; i++) send(-32768, 1'b0, 0, "R4");
    drain();
    check(int'($signed(state_out)) == -32768, "R4", "negative clamp of state",
          int'($signed(state_out)), -32768);
    check(int'($signed(out_sample)) == -32768, "R4", "negative clamp of output",
          int'($signed(out_sample)), -32768);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule